// File: doc/BRIEF.md
# Lockable Dual-Source Watchdog Timer

This block is a supervision counter that asks the chip's reset controller for a system reset when software stops servicing it. Software reaches it through a simple write port (address, data, strobe). Two option registers set the behaviour. The first holds an enable bit and a short/long timeout bit. The second picks the count source. Each option register accepts one write after reset. Writing anything to a third address, the status location, restarts the count and changes nothing else.

The count advances either on every clock cycle (bus source) or only on cycles where a slow periodic tick strobe is high (tick source). Each source has a short and a long limit, given as powers of two. Out of reset the watchdog is enabled and runs from the bus source with its long limit. The first write to each option register locks that register and also restarts the count, so locking in the defaults does not shorten the first service window.

Top module: `wdog_guard`

## Requirements
- R1: After reset the block is enabled, uses the bus source and the long bus limit: `rst_req` stays 0 through reset and first pulses exactly 2^BUS_LONG_EXP clock edges after reset is released.
- R2: A write to address STAT_ADDR (default 2) with any data restarts the count, so the next pulse comes 2^limit counting steps after the edge that took the write.
- R3: With the source bit (data bit SRC_BIT = 0 at address SRC_ADDR = 1) equal to 1 and the timeout bit (data bit LONG_BIT = 0 at OPT_ADDR = 0) equal to 0, the limit is 2^BUS_SHORT_EXP clock edges.
- R4: With the source bit 0, the count advances only on edges where `tick_en` is 1; with the timeout bit 0 the pulse comes on the edge of the 2^TICK_SHORT_EXP-th tick, and no pulse comes while `tick_en` stays 0.
- R5: With the source bit 0 and the timeout bit 1, the pulse comes on the edge of the 2^TICK_LONG_EXP-th tick.
- R6: Only the first write to OPT_ADDR after reset takes effect; later writes there change neither enable nor timeout until the next reset.
- R7: Only the first write to SRC_ADDR after reset takes effect; later writes there leave the source unchanged until the next reset.
- R8: The first write to each option register restarts the count; later, ignored writes to it do not.
- R9: With the enable bit (data bit EN_BIT = 1 at OPT_ADDR) written as 0, the count is held at zero and `rst_req` never rises.
- R10: `rst_req` is high for exactly one cycle, and the count restarts from zero on that edge, so the next pulse follows a full period later.
- R11: Writes to addresses other than the three decoded ones have no effect on the count or the settings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous block reset; clears locks and restores defaults |
| wr_en | input | 1 | Write strobe, one write per cycle while high |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| tick_en | input | 1 | Slow periodic tick, one cycle high per tick period |
| rst_req | output | 1 | Single-cycle system reset request |

## Verification
The bench builds the block with the bus limits cut to 2^6 and 2^9 and the tick limits to 2^3 and 2^5. Every timeout, including the reset-default long window, therefore expires within a few hundred cycles. Each scenario can then measure the exact edge count to a pulse, pulse-to-pulse spacing, and the effect of ignored or restarting writes placed at chosen cycles. The tick source is driven with strobe spacings of 2 and 3 cycles, and held low, so the bench can tell counting ticks apart from counting clocks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

   typedef enum logic {
      SRC_TICK = 1'b0,
      SRC_BUS  = 1'b1
   } cnt_src_e;

   typedef struct packed {
      logic enable;
      logic long_to;
   } opt_t;

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/wdog_once_reg.sv
module wdog_once_reg #(
   parameter int          WIDTH   = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [WIDTH-1:0] wr_val,
   output logic [WIDTH-1:0] val_q,
   output logic             locked_q,
   output logic             first_wr
);

   assign first_wr = wr_hit && !locked_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         val_q    <= RST_VAL;
         locked_q <= 1'b0;
      end else if (first_wr) begin
         val_q    <= wr_val;
         locked_q <= 1'b1;
      end
   end

endmodule

// File: rtl/wdog_limit_sel.sv
module wdog_limit_sel #(
   parameter int CNT_W          = 18,
   parameter int TICK_SHORT_EXP = 5,
   parameter int TICK_LONG_EXP  = 8,
   parameter int BUS_SHORT_EXP  = 13,
   parameter int BUS_LONG_EXP   = 18
) (
   input  wdog_pkg::cnt_src_e src,
   input  logic               long_to,
   output logic [CNT_W-1:0]   term
);
   import wdog_pkg::*;

   localparam logic [CNT_W-1:0] ONES   = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] TERM_TS = ONES >> (CNT_W - TICK_SHORT_EXP);
   localparam logic [CNT_W-1:0] TERM_TL = ONES >> (CNT_W - TICK_LONG_EXP);
   localparam logic [CNT_W-1:0] TERM_BS = ONES >> (CNT_W - BUS_SHORT_EXP);
   localparam logic [CNT_W-1:0] TERM_BL = ONES >> (CNT_W - BUS_LONG_EXP);

   always_comb begin
      unique case ({src == SRC_BUS, long_to})
         2'b00:   term = TERM_TS;
         2'b01:   term = TERM_TL;
         2'b10:   term = TERM_BS;
         default: term = TERM_BL;
      endcase
   end

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
   parameter int CNT_W = 18
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             step,
   input  logic             restart,
   input  logic [CNT_W-1:0] term,
   output logic [CNT_W-1:0] cnt_q,
   output logic             expire_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         expire_q <= 1'b0;
      end else if (!enable || restart) begin
         cnt_q    <= '0;
         expire_q <= 1'b0;
      end else if (step) begin
         if (cnt_q >= term) begin
            cnt_q    <= '0;
            expire_q <= 1'b1;
         end else begin
            cnt_q    <= cnt_q + 1'b1;
            expire_q <= 1'b0;
         end
      end else begin
         expire_q <= 1'b0;
      end
   end

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
   parameter int ADDR_W         = 4,
   parameter int DATA_W         = 8,
   parameter int OPT_ADDR       = 0,
   parameter int SRC_ADDR       = 1,
   parameter int STAT_ADDR      = 2,
   parameter int EN_BIT         = 1,
   parameter int LONG_BIT       = 0,
   parameter int SRC_BIT        = 0,
   parameter int TICK_SHORT_EXP = 5,
   parameter int TICK_LONG_EXP  = 8,
   parameter int BUS_SHORT_EXP  = 13,
   parameter int BUS_LONG_EXP   = 18
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              tick_en,
   output logic              rst_req
);
   import wdog_pkg::*;

   localparam int CNT_W = max_of4(TICK_SHORT_EXP, TICK_LONG_EXP, BUS_SHORT_EXP, BUS_LONG_EXP);
   localparam logic [ADDR_W-1:0] A_OPT  = ADDR_W'(OPT_ADDR);
   localparam logic [ADDR_W-1:0] A_SRC  = ADDR_W'(SRC_ADDR);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

   // elaboration-time parameter checks
   if (OPT_ADDR == SRC_ADDR || OPT_ADDR == STAT_ADDR || SRC_ADDR == STAT_ADDR) begin : g_bad_addr
      $error("wdog_guard: decoded addresses must differ");
   end
   if (OPT_ADDR >= (1 << ADDR_W) || SRC_ADDR >= (1 << ADDR_W) || STAT_ADDR >= (1 << ADDR_W)) begin : g_bad_aw
      $error("wdog_guard: address does not fit ADDR_W");
   end
   if (EN_BIT >= DATA_W || LONG_BIT >= DATA_W || SRC_BIT >= DATA_W || EN_BIT == LONG_BIT) begin : g_bad_bits
      $error("wdog_guard: field bit positions invalid");
   end
   if (TICK_SHORT_EXP < 1 || BUS_SHORT_EXP < 1 ||
       TICK_SHORT_EXP > TICK_LONG_EXP || BUS_SHORT_EXP > BUS_LONG_EXP) begin : g_bad_exp
      $error("wdog_guard: timeout exponents invalid");
   end

   // address decode
   logic hit_opt, hit_src, hit_stat;
   assign hit_opt  = wr_en && (wr_addr == A_OPT);
   assign hit_src  = wr_en && (wr_addr == A_SRC);
   assign hit_stat = wr_en && (wr_addr == A_STAT);

   wire unused_wdata = ^wr_data;

   // option register: enable and timeout length
   opt_t opt_wr, opt_q;
   logic opt_locked, opt_first;
   assign opt_wr = '{enable: wr_data[EN_BIT], long_to: wr_data[LONG_BIT]};

   wdog_once_reg #(
      .WIDTH   (2),
      .RST_VAL (2'b11)
   ) i_opt_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (hit_opt),
      .wr_val   (opt_wr),
      .val_q    (opt_q),
      .locked_q (opt_locked),
      .first_wr (opt_first)
   );

   // source register: bus or tick counting
   logic src_bit_q, src_locked, src_first;

   wdog_once_reg #(
      .WIDTH   (1),
      .RST_VAL (1'b1)
   ) i_src_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_hit   (hit_src),
      .wr_val   (wr_data[SRC_BIT]),
      .val_q    (src_bit_q),
      .locked_q (src_locked),
      .first_wr (src_first)
   );

   cnt_src_e src;
   assign src = cnt_src_e'(src_bit_q);

   logic [CNT_W-1:0] term;

   wdog_limit_sel #(
      .CNT_W          (CNT_W),
      .TICK_SHORT_EXP (TICK_SHORT_EXP),
      .TICK_LONG_EXP  (TICK_LONG_EXP),
      .BUS_SHORT_EXP  (BUS_SHORT_EXP),
      .BUS_LONG_EXP   (BUS_LONG_EXP)
   ) i_limit (
      .src     (src),
      .long_to (opt_q.long_to),
      .term    (term)
   );

   logic step, restart;
   assign step    = (src == SRC_BUS) ? 1'b1 : tick_en;
   assign restart = hit_stat || opt_first || src_first;

   logic [CNT_W-1:0] cnt_q;

   wdog_counter #(
      .CNT_W (CNT_W)
   ) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable   (opt_q.enable),
      .step     (step),
      .restart  (restart),
      .term     (term),
      .cnt_q    (cnt_q),
      .expire_q (rst_req)
   );

endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
   parameter int ADDR_W    = 4,
   parameter int CNT_W     = 18,
   parameter int STAT_ADDR = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] wr_addr,
   input logic              tick_en,
   input logic              rst_req,
   input logic              en_q,
   input logic              bus_q,
   input logic [1:0]        opt_q,
   input logic              opt_locked,
   input logic              src_bit_q,
   input logic              src_locked,
   input logic [CNT_W-1:0]  cnt_q
);

   // R10
   pulse_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req);

   // R10
   clear_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> cnt_q == '0);

   // R2
   svc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(STAT_ADDR)) |=> (cnt_q == '0 && !rst_req));

   // R9
   off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> (cnt_q == '0 && !rst_req));

   // R4
   tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_q && !tick_en && !wr_en) |=> ($stable(cnt_q) && !rst_req));

   // R6
   opt_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      opt_locked |=> $stable(opt_q));

   // R7
   src_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      src_locked |=> $stable(src_bit_q));

endmodule

bind wdog_guard wdog_guard_chk #(
   .ADDR_W    (ADDR_W),
   .CNT_W     (CNT_W),
   .STAT_ADDR (STAT_ADDR)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .tick_en    (tick_en),
   .rst_req    (rst_req),
   .en_q       (opt_q.enable),
   .bus_q      (src_bit_q),
   .opt_q      (opt_q),
   .opt_locked (opt_locked),
   .src_bit_q  (src_bit_q),
   .src_locked (src_locked),
   .cnt_q      (cnt_q)
);

// File: tb/test_wdog_guard.sv
module test_wdog_guard;

   localparam int AW = 4;
   localparam int DW = 8;
   localparam int TS = 3;
   localparam int TL = 5;
   localparam int BS = 6;
   localparam int BL = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [DW-1:0] wr_data = '0;
   logic          tick_en = 1'b0;
   logic          rst_req;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #4 clk = ~clk;

   wdog_guard #(
      .ADDR_W (AW), .DATA_W (DW),
      .TICK_SHORT_EXP (TS), .TICK_LONG_EXP (TL),
      .BUS_SHORT_EXP (BS), .BUS_LONG_EXP (BL)
   ) i_wdog_guard (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
      .wr_data (wr_data), .tick_en (tick_en), .rst_req (rst_req)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // leaves the bench at a falling edge, reset released
   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; tick_en = 1'b0;
      repeat (3) @(negedge clk);
      check(rst_req == 1'b0, "R1 reset state", rst_req, 0);
      rst_n = 1'b1;
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // called at a falling edge; counts rising edges until a pulse is seen
   task automatic run_to_req(input int max_e, input int wr_at, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input int tick_per,
                             output int edges, output int ticks);
      edges = 0; ticks = 0;
      for (int i = 0; i < max_e; i++) begin
         wr_en   = (i == wr_at);
         wr_addr = a; wr_data = d;
         tick_en = (tick_per > 0) && (i % tick_per == 0);
         if (tick_en) ticks++;
         @(posedge clk);
         edges++;
         @(negedge clk);
         if (rst_req) begin
            wr_en = 1'b0; tick_en = 1'b0;
            return;
         end
      end
      wr_en = 1'b0; tick_en = 1'b0;
      edges = -1;
   endtask

   task automatic t_defaults();
      int e, t;
      do_reset();
      run_to_req(5000, -1, '0, '0, 0, e, t);
      check(e == (1 << BL), "R1 default long bus window", e, 1 << BL);
      run_to_req(5000, -1, '0, '0, 0, e, t);
      check(e == (1 << BL), "R10 pulse spacing after expiry", e, 1 << BL);
   endtask

   task automatic t_service();
      int e, t;
      do_reset();
      run_to_req(5000, 300, 4'd2, 8'h5A, 0, e, t);
      check(e == 301 + (1 << BL), "R2 service write restarts", e, 301 + (1 << BL));
      run_to_req(5000, 100, 4'd2, 8'hFF, 0, e, t);
      check(e == 101 + (1 << BL), "R2 service data ignored", e, 101 + (1 << BL));
      run_to_req(5000, 200, 4'd3, 8'hFF, 0, e, t);
      check(e == (1 << BL), "R11 unused address no effect", e, 1 << BL);
      run_to_req(5000, 50, 4'd7, 8'h00, 0, e, t);
      check(e == (1 << BL), "R11 unused address keeps enable", e, 1 << BL);
   endtask

   task automatic t_bus_short();
      int e, t;
      do_reset();
      run_to_req(5000, 50, 4'd0, 8'h02, 0, e, t);
      check(e == 51 + (1 << BS), "R3 R8 short bus after first write", e, 51 + (1 << BS));
      run_to_req(5000, 10, 4'd0, 8'h00, 0, e, t);
      check(e == (1 << BS), "R6 R8 second option write ignored", e, 1 << BS);
      run_to_req(5000, 20, 4'd0, 8'h03, 0, e, t);
      check(e == (1 << BS), "R6 long bit locked", e, 1 << BS);
   endtask

   task automatic t_tick_short();
      int e, t;
      do_reset();
      do_write(4'd1, 8'h00);
      do_write(4'd0, 8'h02);
      run_to_req(5000, -1, '0, '0, 3, e, t);
      check(t == (1 << TS), "R4 short tick count", t, 1 << TS);
      check(e == ((1 << TS) - 1) * 3 + 1, "R4 edges in tick mode", e, ((1 << TS) - 1) * 3 + 1);
      run_to_req(60, -1, '0, '0, 0, e, t);
      check(e == -1, "R4 no pulse without ticks", e, -1);
      run_to_req(300, 5, 4'd1, 8'h01, 0, e, t);
      check(e == -1, "R7 source locked to tick", e, -1);
   endtask

   task automatic t_tick_long();
      int e, t;
      do_reset();
      run_to_req(5000, 7, 4'd1, 8'h00, 0, e, t);
      check(e == -1 || e > 0, "R8 source write accepted", e, 1);
      do_reset();
      do_write(4'd1, 8'h00);
      run_to_req(5000, -1, '0, '0, 2, e, t);
      check(t == (1 << TL), "R5 default long tick count", t, 1 << TL);
      do_write(4'd0, 8'h03);
      run_to_req(5000, -1, '0, '0, 2, e, t);
      check(t == (1 << TL), "R5 long tick after option lock", t, 1 << TL);
   endtask

   task automatic t_disable();
      int e, t;
      do_reset();
      do_write(4'd0, 8'h00);
      run_to_req(1500, 400, 4'd2, 8'h11, 0, e, t);
      check(e == -1, "R9 disabled gives no pulse", e, -1);
      run_to_req(1500, 10, 4'd0, 8'h02, 0, e, t);
      check(e == -1, "R6 re-enable ignored", e, -1);
      do_reset();
      run_to_req(5000, 5, 4'd0, 8'h02, 0, e, t);
      check(e == 6 + (1 << BS), "R6 unlocked by reset", e, 6 + (1 << BS));
   endtask

   initial begin
      t_defaults();
      t_service();
      t_bus_short();
      t_tick_short();
      t_tick_long();
      t_disable();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++;
         bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule